// File: doc/BRIEF.md
# Registered-Mode Output Macrocell Bank

This block is the output stage of a small programmable logic device working in its registered architecture. A programmable AND array forms product terms. Its inputs are the dedicated inputs and one feedback signal from each of the eight macrocells, each available in true and complement form. Each macrocell ORs its product terms and applies a programmable polarity. It then either holds the result in a flip-flop clocked by the shared clock, or passes it straight through to a bidirectional pin.

Each macrocell has its own static control bits. One picks the registered or the combinational I/O role, one sets the polarity, and one sets totem-pole or open-drain drive. Registered outputs share one active-low enable input. A combinational I/O is enabled by its own last product term. Pins are modelled as separate in, out and enable signals, so the pad resolution stays outside the block.

Top module: `gal_reg_bank`

## Requirements
- R1: While rst_ni is low every macrocell flip-flop holds 0, so a registered pin shows 0 with pol_i=1 and 1 with pol_i=0.
- R2: A registered macrocell (io_role_i bit 0) captures the OR of all N_PT product terms on the rising clk_i edge. The value appears on pad_o after that edge and not before.
- R3: A combinational macrocell (io_role_i bit 1) drives the OR of product terms 0 to N_PT-2 on pad_o in the same cycle, with no clock edge involved.
- R4: With pol_i=1 the pin value equals the sum (or stored bit). With pol_i=0 it is the inverse.
- R5: A product term whose term_en_i bit is 0 contributes 0. An enabled term with no selected literals evaluates to 1. An enabled term is the AND of its selected literals.
- R6: Term t of macrocell m uses term_map_i bits [(m*N_PT+t)*N_COL +: N_COL]. Column 2k selects signal k true and column 2k+1 selects it complemented. Signals 0..N_IN-1 are in_i and signal N_IN+m is the feedback of macrocell m.
- R7: Registered pins are enabled only while oe_ni is 0. With oe_ni at 1 they are all released.
- R8: A combinational macrocell is enabled by its product term N_PT-1, and oe_ni has no effect on it.
- R9: In open-drain style (push_pull_i bit 0) a pin that would otherwise be enabled is enabled only when its output value is 0.
- R10: A registered macrocell feeds the inverse of its flip-flop back into the array. A combinational macrocell feeds back pad_i.
- R11: When sync_mode_i is 1, or a macrocell's arch_sel_i bit is 0, that macrocell's pad_oe_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock for all macrocell flip-flops |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_ni | input | 1 | Shared active-low enable for registered pins |
| in_i | input | N_IN | Dedicated array inputs |
| pad_i | input | N_MC | Pin value seen at each macrocell pad |
| pad_o | output | N_MC | Output value per macrocell |
| pad_oe_o | output | N_MC | Pad drive enable per macrocell |
| term_map_i | input | N_MC*N_PT*N_COL | Literal selection per product term |
| term_en_i | input | N_MC*N_PT | Enable per product term |
| sync_mode_i | input | 1 | Global mode bit, 0 selects the registered architecture |
| arch_sel_i | input | N_MC | Per-macrocell mode bit, 1 required for operation |
| io_role_i | input | N_MC | 0 registered output, 1 combinational I/O |
| pol_i | input | N_MC | 1 active high, 0 active low |
| push_pull_i | input | N_MC | 1 totem-pole, 0 open-drain |

## Verification
The bench goes after how the two roles differ. If the last term were folded into a combinational sum, pins would switch on their own enable term. If oe_ni reached combinational pins, or the last term were not routed as their enable, pins would be released while oe_ni is high. A swapped feedback source, or true feedback where the complement belongs, would make registered cells that see their own feedback stop toggling or follow the wrong pad. Disabled terms, empty terms, open-drain release at value 1, and the mode gate are each driven directly. A design that got any of them wrong would show a wrong pad_oe_o or pad_o against the bench's own sum-of-products model.

// File: rtl/gal_reg_pkg.sv
package gal_reg_pkg;
  localparam int unsigned DEF_N_IN = 8;
  localparam int unsigned DEF_N_MC = 8;
  localparam int unsigned DEF_N_PT = 8;

  typedef struct packed {
    logic mode_ok;
    logic comb;
    logic pol;
    logic totem;
  } mc_ctrl_t;
endpackage

// File: rtl/gal_and_array.sv
module gal_and_array #(
  parameter int unsigned N_COL = 32,
  parameter int unsigned N_PT  = 8
) (
  input  logic [N_COL-1:0]      lit_i,
  input  logic [N_PT*N_COL-1:0] map_i,
  input  logic [N_PT-1:0]       en_i,
  output logic [N_PT-1:0]       pt_o
);
  for (genvar t = 0; t < N_PT; t++) begin : g_pt
    // unselected columns read as 1, so an empty term is 1
    assign pt_o[t] = en_i[t] & (&(lit_i | ~map_i[t*N_COL +: N_COL]));
  end
endmodule

// File: rtl/gal_mc_cell.sv
module gal_mc_cell
  import gal_reg_pkg::*;
#(
  parameter int unsigned N_PT = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            oe_ni,
  input  mc_ctrl_t        ctrl_i,
  input  logic [N_PT-1:0] pt_i,
  output logic            q_o,
  output logic            pad_o,
  output logic            pad_oe_o
);
  localparam int unsigned OE_PT = N_PT - 1;

  logic sum_reg, sum_comb, val, out_v, role_en;

  assign sum_reg  = |pt_i;
  assign sum_comb = |pt_i[OE_PT-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= sum_reg;
  end

  assign val      = ctrl_i.comb ? sum_comb : q_o;
  assign out_v    = ctrl_i.pol ? val : ~val;
  assign role_en  = ctrl_i.comb ? pt_i[OE_PT] : ~oe_ni;
  assign pad_o    = out_v;
  assign pad_oe_o = ctrl_i.mode_ok & role_en & (ctrl_i.totem | ~out_v);

  p_reg_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !ctrl_i.comb && ctrl_i.pol && $past(!ctrl_i.comb && ctrl_i.pol))
      |-> pad_o == $past(|pt_i));
  p_reg_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.comb && oe_ni) |-> !pad_oe_o);
  p_comb_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.mode_ok && ctrl_i.comb && ctrl_i.totem) |-> pad_oe_o == pt_i[OE_PT]);
  p_od_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.totem && pad_oe_o) |-> !pad_o);
  p_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.mode_ok |-> !pad_oe_o);
endmodule

// File: rtl/gal_reg_bank.sv
module gal_reg_bank
  import gal_reg_pkg::*;
#(
  parameter int unsigned N_IN  = DEF_N_IN,
  parameter int unsigned N_MC  = DEF_N_MC,
  parameter int unsigned N_PT  = DEF_N_PT,
  parameter int unsigned N_COL = 2 * (N_IN + N_MC)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        oe_ni,
  input  logic [N_IN-1:0]             in_i,
  input  logic [N_MC-1:0]             pad_i,
  output logic [N_MC-1:0]             pad_o,
  output logic [N_MC-1:0]             pad_oe_o,
  input  logic [N_MC*N_PT*N_COL-1:0]  term_map_i,
  input  logic [N_MC*N_PT-1:0]        term_en_i,
  input  logic                        sync_mode_i,
  input  logic [N_MC-1:0]             arch_sel_i,
  input  logic [N_MC-1:0]             io_role_i,
  input  logic [N_MC-1:0]             pol_i,
  input  logic [N_MC-1:0]             push_pull_i
);
  localparam int unsigned N_SIG  = N_IN + N_MC;
  localparam int unsigned MC_MAP = N_PT * N_COL;

  logic [N_SIG-1:0] sig;
  logic [N_COL-1:0] lit;
  logic [N_MC-1:0]  q, fb;

  assign sig = {fb, in_i};

  for (genvar k = 0; k < N_SIG; k++) begin : g_lit
    assign lit[2*k]   = sig[k];
    assign lit[2*k+1] = ~sig[k];
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    logic [N_PT-1:0] pt;
    mc_ctrl_t        ctrl;

    assign fb[m] = io_role_i[m] ? pad_i[m] : ~q[m];
    assign ctrl  = '{mode_ok: ~sync_mode_i & arch_sel_i[m], comb: io_role_i[m],
                     pol: pol_i[m], totem: push_pull_i[m]};

    gal_and_array #(.N_COL(N_COL), .N_PT(N_PT)) u_arr (
      .lit_i (lit),
      .map_i (term_map_i[m*MC_MAP +: MC_MAP]),
      .en_i  (term_en_i[m*N_PT +: N_PT]),
      .pt_o  (pt)
    );

    gal_mc_cell #(.N_PT(N_PT)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .oe_ni    (oe_ni),
      .ctrl_i   (ctrl),
      .pt_i     (pt),
      .q_o      (q[m]),
      .pad_o    (pad_o[m]),
      .pad_oe_o (pad_oe_o[m])
    );

    p_fb_comb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (io_role_i[m] && pol_i[m]) |-> (lit[2*(N_IN+m)] == pad_i[m]));
  end
endmodule

// File: tb/gal_reg_bank_test.sv
module gal_reg_bank_test;
  localparam int N_IN = 8, N_MC = 8, N_PT = 8;
  localparam int N_SIG = N_IN + N_MC, N_COL = 2 * N_SIG;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0, oe_ni = 1'b0, sync_mode = 1'b0;
  logic [N_IN-1:0] din = '0;
  logic [N_MC-1:0] pad_in = '0, pad_o, pad_oe, ac0 = '1, role = '0, pol = '1, pp = '1;
  logic [N_MC*N_PT*N_COL-1:0] tmap = '0;
  logic [N_MC*N_PT-1:0] ten = '1;
  logic [N_MC-1:0] q_m = '0, nxt_m, e_o, e_oe;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gal_reg_bank #(.N_IN(N_IN), .N_MC(N_MC), .N_PT(N_PT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .oe_ni(oe_ni), .in_i(din), .pad_i(pad_in),
    .pad_o(pad_o), .pad_oe_o(pad_oe), .term_map_i(tmap), .term_en_i(ten),
    .sync_mode_i(sync_mode), .arch_sel_i(ac0), .io_role_i(role), .pol_i(pol),
    .push_pull_i(pp));

  task automatic model();
    logic [N_SIG-1:0] s;
    logic [N_COL-1:0] lit;
    for (int k = 0; k < N_IN; k++) s[k] = din[k];
    for (int m = 0; m < N_MC; m++) s[N_IN+m] = role[m] ? pad_in[m] : ~q_m[m];
    for (int k = 0; k < N_SIG; k++) begin lit[2*k] = s[k]; lit[2*k+1] = ~s[k]; end
    for (int m = 0; m < N_MC; m++) begin
      logic [N_PT-1:0] pt;
      logic s8, s7, v, o, en;
      for (int t = 0; t < N_PT; t++) begin
        pt[t] = ten[m*N_PT+t];
        for (int c = 0; c < N_COL; c++)
          if (tmap[(m*N_PT+t)*N_COL+c] && !lit[c]) pt[t] = 1'b0;
      end
      s8 = |pt;
      s7 = |pt[N_PT-2:0];
      nxt_m[m] = rst_ni ? s8 : 1'b0;
      v = role[m] ? s7 : q_m[m];
      o = pol[m] ? v : ~v;
      en = role[m] ? pt[N_PT-1] : ~oe_ni;
      e_o[m] = o;
      e_oe[m] = en & ~sync_mode & ac0[m] & (pp[m] | ~o);
    end
  endtask

  task automatic check_all(string tag);
    model();
    for (int m = 0; m < N_MC; m++) begin
      checks++;
      if (pad_o[m] !== e_o[m] || pad_oe[m] !== e_oe[m]) begin
        errors++;
        $display("FAIL %s mc%0d: pad_o=%b oe=%b expected pad_o=%b oe=%b",
                 tag, m, pad_o[m], pad_oe[m], e_o[m], e_oe[m]);
      end
    end
  endtask

  // called just after a negedge: check, clock, return at next negedge
  task automatic cycle(string tag);
    #1 check_all(tag);
    @(posedge clk);
    q_m = nxt_m;
    @(negedge clk);
  endtask

  task automatic rand_map();
    tmap = '0;
    for (int i = 0; i < N_MC*N_PT; i++) begin
      int n = 1 + int'($urandom % 3);
      for (int j = 0; j < n; j++) tmap[i*N_COL + int'($urandom % N_COL)] = 1'b1;
      ten[i] = ($urandom % 8) != 0;
    end
  endtask

  task automatic rand_cfg();
    rand_map();
    role = N_MC'($urandom); pol = N_MC'($urandom); pp = N_MC'($urandom);
    sync_mode = ($urandom % 16) == 0;
    for (int m = 0; m < N_MC; m++) ac0[m] = ($urandom % 16) != 0;
  endtask

  task automatic rand_in();
    din = N_IN'($urandom); pad_in = N_MC'($urandom); oe_ni = ($urandom % 4) == 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rand_map();
    pol = 8'b1010_0101;
    @(negedge clk);
    cycle("R1 reset state");
    cycle("R1 reset held");
    rst_ni = 1'b1;

    for (int i = 0; i < 3000; i++) begin
      if (i % 40 == 0) rand_cfg();
      rand_in();
      cycle("R2/R3/R4/R5/R6/R10 random");
    end

    // R7: shared enable releases registered pins
    sync_mode = 0; ac0 = '1; role = '0; pp = '1; rand_map(); oe_ni = 1'b1;
    cycle("R7 oe high");
    oe_ni = 1'b0;
    cycle("R7 oe low");

    // R8: last term enables combinational pins, shared enable ignored
    role = '1; ten = '1;
    for (int m = 0; m < N_MC; m++) tmap[(m*N_PT+N_PT-1)*N_COL +: N_COL] = '0;
    oe_ni = 1'b1;
    cycle("R8 empty last term enables");
    for (int m = 0; m < N_MC; m++) ten[m*N_PT+N_PT-1] = 1'b0;
    oe_ni = 1'b0;
    cycle("R8 disabled last term releases");

    // R5: all terms disabled, then empty terms
    role = 8'h0F; ten = '0; oe_ni = 1'b0;
    cycle("R5 all disabled");
    cycle("R5 all disabled clocked");
    tmap = '0; ten = '1;
    cycle("R5 empty terms");
    cycle("R5 empty terms clocked");

    // R6: term 0 reads one dedicated input, true then complement
    role = '1; ten = '0; tmap = '0;
    for (int m = 0; m < N_MC; m++) begin
      ten[m*N_PT] = 1'b1; ten[m*N_PT+N_PT-1] = 1'b1;
      tmap[(m*N_PT)*N_COL + 2*m] = 1'b1;
    end
    for (int i = 0; i < 8; i++) begin din = N_IN'($urandom); cycle("R6 true column"); end
    for (int m = 0; m < N_MC; m++) begin
      tmap[(m*N_PT)*N_COL + 2*m] = 1'b0; tmap[(m*N_PT)*N_COL + 2*m + 1] = 1'b1;
    end
    for (int i = 0; i < 8; i++) begin din = N_IN'($urandom); cycle("R6 complement column"); end

    // R10: registered cells toggle on own true feedback; comb cells follow pad_i
    tmap = '0; ten = '0; role = 8'hF0;
    for (int m = 0; m < N_MC; m++) begin
      ten[m*N_PT] = 1'b1; ten[m*N_PT+N_PT-1] = 1'b1;
      tmap[(m*N_PT)*N_COL + 2*(N_IN+m)] = 1'b1;
    end
    for (int i = 0; i < 8; i++) begin pad_in = N_MC'($urandom); cycle("R10 feedback"); end

    // R9: open-drain
    pp = '0; role = N_MC'($urandom); rand_map();
    for (int i = 0; i < 30; i++) begin rand_in(); cycle("R9 open drain"); end
    pp = '1;

    // R11: mode gate
    sync_mode = 1'b1;
    for (int i = 0; i < 4; i++) begin rand_in(); cycle("R11 global bit"); end
    sync_mode = 1'b0; ac0 = 8'h3C;
    for (int i = 0; i < 4; i++) begin rand_in(); cycle("R11 per-cell bit"); end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule